// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Global Enable

This block decides, cycle by cycle, whether a single-issue processor core should leave its instruction stream to service an interrupt, and if so which vector to use. It has a parameterised number of request lines. A per-source mask chosen at elaboration makes each line either a sticky, flag-latched source or a level-sensitive source. Each line has its own enable, and a global enable bit sits over all of them. When the core accepts an offered vector, the arbiter clears the global enable and clears the flag of the source that was taken. It then raises an entry-busy window for as long as the vector entry sequence lasts, and that window is longer when the core was asleep.

The core tells the arbiter when an instruction retires, when a set-enable, clear-enable or return-from-interrupt instruction executes, and when a multi-cycle instruction is still in flight. From this the arbiter applies the ordering rules. After a return or a set-enable, one further instruction must retire before any pending source is offered. A clear-enable blocks the offer in the very cycle it executes. Vector index 0 is kept for reset, so source `i` is offered as index `i+1`.

Top module: `irq_arbiter`

## Requirements
- R1: While a vector is offered, `vec_idx` equals one plus the lowest-numbered source that is both pending and enabled. Index 0 is never offered.
- R2: A take is `irq_ack` high in a cycle with `vec_valid` high. It clears `gie` at the next edge. Nothing is offered while `gie` is low.
- R3: A flag-type source sets its `flag_q` bit one cycle after `irq_in` is high, whatever its `src_en` bit and `gie` are. The bit holds until it is cleared.
- R4: A flag bit is cleared by a take of its own source. It is also cleared by writing a one to its `flag_clr` bit.
- R5: Sources whose bit in `LEVEL_MASK` is 1 (by default sources 4 to 7) have no flag, and their `flag_q` bit reads 0. They request service only in cycles where `irq_in` is high.
- R6: `reti` sets `gie`. No vector is offered until a later `instr_retire` strobe has been seen after the return.
- R7: `gie_set` sets `gie`. The same one-retire gap as in R6 applies before any vector is offered.
- R8: `gie_clr` suppresses `vec_valid` in the same cycle, even when a request arrives in that cycle. It clears `gie` at the next edge.
- R9: No vector is offered while `multi_busy` is high or while `entry_busy` is high. An `irq_ack` with no vector offered has no effect.
- R10: After a take, `entry_busy` stays high for `RESP_CYCLES` cycles (default 4). It stays high for `RESP_CYCLES + WAKE_CYCLES` cycles (default 8) if `sleeping` was high at the take.
- R11: After reset, `vec_valid`, `gie`, `entry_busy` and every `flag_q` bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Request condition per source |
| src_en | input | NUM_SRC | Per-source enable |
| flag_clr | input | NUM_SRC | Write-one-to-clear strobes for flags |
| flag_q | output | NUM_SRC | Latched flags (0 for level sources) |
| gie_set | input | 1 | Set-enable instruction executed |
| gie_clr | input | 1 | Clear-enable instruction executed |
| reti | input | 1 | Return-from-interrupt executed |
| instr_retire | input | 1 | An instruction retired this cycle |
| multi_busy | input | 1 | Multi-cycle instruction still in flight |
| sleeping | input | 1 | Core is in a sleep mode |
| irq_ack | input | 1 | Core accepts the offered vector |
| vec_valid | output | 1 | A vector is offered |
| vec_idx | output | IDX_W | Offered vector index (source + 1) |
| gie | output | 1 | Global interrupt enable |
| entry_busy | output | 1 | Vector entry sequence in progress |

## Verification
The embedded assertions check four rules on every cycle: a take clears the global enable, a return sets it, nothing is offered in the cycle after a set-enable or return, and the offered index never skips a lower pending source. They also check that a flag holds until it is cleared, and that a take opens the entry window. Only the bench scenarios can show that the gap lasts exactly until the next retire strobe, and that a clear-enable blocks a request arriving in its own cycle. The bench scenarios also measure the exact lengths of the entry window with and without the sleep extension.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic {
      KIND_FLAG  = 1'b0,
      KIND_LEVEL = 1'b1
   } src_kind_e;

   function automatic int resp_len(input int base, input int wake, input logic asleep);
      return asleep ? base + wake : base;
   endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int          NUM_SRC    = 8,
   parameter logic [63:0] LEVEL_MASK = 64'hF0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] sw_clr,
   input  logic [NUM_SRC-1:0] hw_clr,
   output logic [NUM_SRC-1:0] flag_q,
   output logic [NUM_SRC-1:0] pending
);
   import irq_pkg::*;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam src_kind_e KIND = LEVEL_MASK[i] ? KIND_LEVEL : KIND_FLAG;
      if (KIND == KIND_LEVEL) begin : g_level
         assign flag_q[i]  = 1'b0;
         assign pending[i] = irq_in[i] & src_en[i];
      end else begin : g_flag
         logic flag_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flag_r <= 1'b0;
            else if (irq_in[i])
               flag_r <= 1'b1;
            else if (sw_clr[i] || hw_clr[i])
               flag_r <= 1'b0;
         end
         assign flag_q[i]  = flag_r;
         assign pending[i] = flag_r & src_en[i];

         // R3
         flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_r && !sw_clr[i] && !hw_clr[i]) |=> flag_r);
         // R3
         flag_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_in[i] |=> flag_r);
      end
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 4
) (
   input  logic [NUM_SRC-1:0] pending,
   output logic               any,
   output logic [IDX_W-1:0]   idx,
   output logic [NUM_SRC-1:0] sel_oh
);
   assign any = |pending;

   always_comb begin
      idx    = '0;
      sel_oh = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pending[i]) begin
            idx       = IDX_W'(i + 1);
            sel_oh    = '0;
            sel_oh[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic gie_set,
   input  logic gie_clr,
   input  logic reti,
   input  logic take,
   input  logic retire,
   output logic gie_q,
   output logic gap_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gie_q <= 1'b0;
      else if (take || gie_clr)
         gie_q <= 1'b0;
      else if (gie_set || reti)
         gie_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= 1'b0;
      else if (gie_set || reti)
         gap_q <= 1'b1;
      else if (retire)
         gap_q <= 1'b0;
   end

   // R2
   gie_drop_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !gie_q);
   // R6
   reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !take && !gie_clr) |=> gie_q);
   // R8
   clr_drops_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gie_clr |=> !gie_q);
endmodule

// File: rtl/irq_resp_timer.sv
module irq_resp_timer #(
   parameter int RESP_CYCLES = 4,
   parameter int WAKE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic sleeping,
   output logic busy
);
   localparam int MAX_LEN = RESP_CYCLES + WAKE_CYCLES;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   if (WAKE_CYCLES == 0) begin : g_nowake
      assign load_val = CNT_W'(RESP_CYCLES);
   end else begin : g_wake
      assign load_val = sleeping ? CNT_W'(MAX_LEN) : CNT_W'(RESP_CYCLES);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (take)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   // R10
   entry_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> busy);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int          NUM_SRC     = 8,
   parameter logic [63:0] LEVEL_MASK  = 64'hF0,
   parameter int          RESP_CYCLES = 4,
   parameter int          WAKE_CYCLES = 4,
   localparam int         IDX_W       = $clog2(NUM_SRC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] flag_clr,
   output logic [NUM_SRC-1:0] flag_q,
   input  logic               gie_set,
   input  logic               gie_clr,
   input  logic               reti,
   input  logic               instr_retire,
   input  logic               multi_busy,
   input  logic               sleeping,
   input  logic               irq_ack,
   output logic               vec_valid,
   output logic [IDX_W-1:0]   vec_idx,
   output logic               gie,
   output logic               entry_busy
);
   if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_num
      $error("irq_arbiter: NUM_SRC must lie in 1..64");
   end
   if (RESP_CYCLES < 4) begin : g_bad_resp
      $error("irq_arbiter: RESP_CYCLES must be at least 4");
   end
   if (WAKE_CYCLES < 0) begin : g_bad_wake
      $error("irq_arbiter: WAKE_CYCLES must not be negative");
   end

   logic [NUM_SRC-1:0] pending;
   logic [NUM_SRC-1:0] sel_oh;
   logic [NUM_SRC-1:0] hw_clr;
   logic               any_pend;
   logic               gap_q;
   logic               take;

   irq_src_bank #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_in  (irq_in),
      .src_en  (src_en),
      .sw_clr  (flag_clr),
      .hw_clr  (hw_clr),
      .flag_q  (flag_q),
      .pending (pending)
   );

   irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
      .pending (pending),
      .any     (any_pend),
      .idx     (vec_idx),
      .sel_oh  (sel_oh)
   );

   irq_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .gie_set (gie_set),
      .gie_clr (gie_clr),
      .reti    (reti),
      .take    (take),
      .retire  (instr_retire),
      .gie_q   (gie),
      .gap_q   (gap_q)
   );

   irq_resp_timer #(.RESP_CYCLES(RESP_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .sleeping (sleeping),
      .busy     (entry_busy)
   );

   assign vec_valid = gie & ~gie_clr & ~gap_q & ~multi_busy & ~entry_busy & any_pend;
   assign take      = vec_valid & irq_ack;
   assign hw_clr    = take ? sel_oh : '0;

   logic [NUM_SRC-1:0] below_mask;
   always_comb begin
      below_mask = '0;
      for (int i = 0; i < NUM_SRC; i++)
         if (IDX_W'(i + 1) < vec_idx) below_mask[i] = 1'b1;
   end

   // R1
   lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> ((pending & below_mask) == '0) && (vec_idx != '0));
   // R7
   enable_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gie_set || reti) |=> !vec_valid);
   // R9
   no_offer_in_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !vec_valid);
endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
   localparam int N     = 8;
   localparam int IDX_W = $clog2(N + 1);
   localparam logic [7:0] LVL = 8'hF0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] irq_in = '0, src_en = '0, flag_clr = '0, flag_q;
   logic gie_set = 0, gie_clr = 0, reti = 0, instr_retire = 0;
   logic multi_busy = 0, sleeping = 0, irq_ack = 0;
   logic vec_valid, gie, entry_busy;
   logic [IDX_W-1:0] vec_idx;

   int n_run = 0, n_fail = 0;

   always #4 clk = ~clk;

   irq_arbiter dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .src_en(src_en),
      .flag_clr(flag_clr), .flag_q(flag_q), .gie_set(gie_set),
      .gie_clr(gie_clr), .reti(reti), .instr_retire(instr_retire),
      .multi_busy(multi_busy), .sleeping(sleeping), .irq_ack(irq_ack),
      .vec_valid(vec_valid), .vec_idx(vec_idx), .gie(gie),
      .entry_busy(entry_busy)
   );

   // {pattern, enables, expected index (0 = nothing offered)}
   localparam logic [23:0] VEC [9] = '{
      {8'h00, 8'hFF, 8'd0}, {8'h01, 8'hFF, 8'd1}, {8'h06, 8'hFF, 8'd2},
      {8'h80, 8'hFF, 8'd8}, {8'h90, 8'hFF, 8'd5}, {8'h0F, 8'h0C, 8'd3},
      {8'hFF, 8'h00, 8'd0}, {8'h30, 8'h20, 8'd6}, {8'hA2, 8'hA0, 8'd6}
   };

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic enable_and_retire();
      gie_set = 1; instr_retire = 1; cyc();
      gie_set = 0; cyc();
      instr_retire = 0;
   endtask

   task automatic count_busy(input string req, input int exp);
      int n = 0;
      for (int k = 0; k < 20; k++) begin
         if (entry_busy) n++;
         cyc();
      end
      chk(req, n, exp);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) cyc();
      // R11 reset state
      chk("R11 vec_valid", vec_valid, 0);
      chk("R11 gie", gie, 0);
      chk("R11 flag_q", flag_q, 0);
      chk("R11 entry_busy", entry_busy, 0);
      rst_n = 1; cyc();

      // R1 priority table
      for (int v = 0; v < 9; v++) begin
         logic [7:0] pat, en, ex;
         pat = VEC[v][23:16]; en = VEC[v][15:8]; ex = VEC[v][7:0];
         irq_in = '0; flag_clr = '1; cyc(); flag_clr = '0;
         src_en = en; irq_in = pat;
         gie_set = 1; instr_retire = 1; cyc();
         gie_set = 0; irq_in = pat & LVL; cyc();
         instr_retire = 0;
         chk("R1 vec_valid", vec_valid, (ex != 0));
         if (ex != 0) begin
            chk("R1 vec_idx", vec_idx, ex);
            irq_ack = 1; cyc(); irq_ack = 0;
            chk("R2 gie after take", gie, 0);
            if (ex <= 4) chk("R4 hw clear", flag_q[ex-1], 0);
            repeat (5) cyc();
         end else begin
            gie_clr = 1; cyc(); gie_clr = 0;
         end
         irq_in = '0;
      end

      // R3 latch while all enables off, R4 software clear
      flag_clr = '1; cyc(); flag_clr = '0; src_en = '0;
      irq_in = 8'h02; cyc(); irq_in = '0;
      chk("R3 flag latched", flag_q, 8'h02);
      chk("R2 nothing offered with gie low", vec_valid, 0);
      cyc();
      chk("R3 flag held", flag_q, 8'h02);
      flag_clr = 8'h02; cyc(); flag_clr = '0;
      chk("R4 sw clear", flag_q, 8'h00);

      // R7 gap after set-enable
      irq_in = 8'h02; cyc(); irq_in = '0; src_en = '1;
      gie_set = 1; cyc(); gie_set = 0;
      chk("R7 gie set", gie, 1);
      chk("R7 gap", vec_valid, 0);
      cyc();
      chk("R7 gap holds until retire", vec_valid, 0);
      instr_retire = 1; cyc(); instr_retire = 0;
      chk("R7 offered after retire", vec_valid, 1);
      chk("R7 idx", vec_idx, 2);

      // R9 multi-cycle instruction defers
      multi_busy = 1; #1;
      chk("R9 multi busy", vec_valid, 0);
      multi_busy = 0; #1;
      chk("R9 released", vec_valid, 1);

      // R10 normal response length
      irq_ack = 1; cyc(); irq_ack = 0;
      chk("R4 hw clear", flag_q[1], 0);
      count_busy("R10 awake length", 4);

      // R6 gap after return
      irq_in = 8'h01; cyc(); irq_in = '0;
      chk("R2 pending but gie low", vec_valid, 0);
      reti = 1; instr_retire = 1; cyc(); reti = 0; instr_retire = 0;
      chk("R6 gie set", gie, 1);
      chk("R6 gap", vec_valid, 0);
      cyc();
      chk("R6 gap holds", vec_valid, 0);
      instr_retire = 1; cyc(); instr_retire = 0;
      chk("R6 offered", vec_valid, 1);
      chk("R6 idx", vec_idx, 1);

      // R10 sleep-extended response
      sleeping = 1; irq_ack = 1; cyc(); irq_ack = 0; sleeping = 0;
      count_busy("R10 asleep length", 8);

      // R8 clear-enable blocks same-cycle request
      enable_and_retire();
      irq_in = 8'h10; gie_clr = 1; #1;
      chk("R8 same cycle block", vec_valid, 0);
      cyc(); gie_clr = 0; #1;
      chk("R8 gie cleared", gie, 0);
      chk("R8 still blocked", vec_valid, 0);
      irq_ack = 1; cyc(); irq_ack = 0;
      chk("R9 stray ack ignored", entry_busy, 0);

      // R5 level source
      irq_in = 8'h10;
      enable_and_retire();
      chk("R5 level offered", vec_valid, 1);
      chk("R5 level idx", vec_idx, 5);
      chk("R5 no flag", flag_q, 0);
      irq_in = '0; #1;
      chk("R5 drops with condition", vec_valid, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule